// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block moves eight-bit channels between serial time-division streams. Each of `NSTR` input streams carries `NCH` channels per frame, one bit per clock and most significant bit first. The block gathers each incoming channel into a byte and stores it in a data memory with three frame banks. Each of the `NSTR` output streams is then rebuilt channel by channel. For every output channel, a connection memory entry names the source stream and channel, or selects a fixed per-channel behaviour: a host message byte, a released line, or a line held high.

The connection memory has one entry per output channel. A host writes single entries. A block-fill command copies one value into every entry. Entries that the host changes are staged and only become active at the next frame boundary. Switched data always comes out exactly two frames after it arrived, whatever the input and output channel positions are. A one-clock frame pulse marks the first bit of channel 0. The block does nothing until it sees the first such pulse.

Top module: `tdm_tsi`

## Requirements
- R1: After reset, every `tx_en` bit and every `tx_data` bit is 0, `busy` is 0, and every connection entry is in high-impedance mode.
- R2: An entry in mode 00 (switch) sends the stored byte of the source named by its payload. The payload holds the source stream in bits [SW+CW-1:CW] and the source channel in bits [CW-1:0]. The byte goes out MSB first with `tx_en` high. Any source can feed any output channel, and one source can feed several outputs.
- R3: A byte received in frame N on a switched path leaves the block in frame N+2, for every pair of input and output channel positions.
- R4: An entry in mode 10 (high-Z) holds `tx_en` low and `tx_data` low for all 8 bits of that channel.
- R5: An entry in mode 01 (message) sends its 8-bit payload, MSB first, with `tx_en` high.
- R6: An entry in mode 11 (drive-high) sends all ones with `tx_en` high.
- R7: A single-entry host write accepted during a frame takes effect from the first bit of the next frame. Up to then, the output still follows the previous entry.
- R8: A `fill_go` pulse accepted while idle raises `busy` on the next cycle. `busy` then stays high for exactly NSTR*NCH cycles, while the host mode and payload value is written to every entry.
- R9: While `busy` is high, host writes and further `fill_go` pulses have no effect. A host write presented together with an accepted `fill_go` is also ignored.
- R10: Before the first frame pulse, all outputs stay disabled. A frame pulse sets the current bit position to 0. The output for bit position p appears in the clock cycle after the edge at which position p is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_pulse | input | 1 | One-cycle marker of bit 7 of channel 0 |
| rx_data | input | NSTR | Serial input streams |
| tx_data | output | NSTR | Serial output streams |
| tx_en | output | NSTR | Per-stream output drive enable |
| host_wr | input | 1 | Write one connection entry |
| host_addr | input | SW+CW | Entry address {output stream, output channel} |
| host_mode | input | 2 | Entry mode (also used as the fill value) |
| host_payload | input | 8 | Entry payload (also used as the fill value) |
| fill_go | input | 1 | Start a block fill of the connection memory |
| busy | output | 1 | Block fill in progress |

## Verification
The bench checks the frame boundary closely. If the data bank rotation is off by one, switched bytes show up one frame early or late. If entries are applied mid-frame, a channel is sent from a half-updated entry. It also checks broadcast of one source to two outputs. It checks the bank edge cases where a channel is read in the same frame slot in which its source is written. A design that read the bank currently being written would leak fresh data with zero delay. The bench also sends host writes and a second fill command while a fill is running. A design that accepted them would corrupt the filled pattern or stretch `busy`.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
    typedef enum logic [1:0] {
        MODE_SWITCH = 2'b00,
        MODE_MSG    = 2'b01,
        MODE_HIZ    = 2'b10,
        MODE_HIGH   = 2'b11
    } cm_mode_e;

    typedef struct packed {
        cm_mode_e   mode;
        logic [7:0] payload;
    } cm_entry_t;

    localparam int NBANK = 3;
endpackage

// File: rtl/tsi_timing.sv
module tsi_timing #(
    parameter int NCH = 32,
    localparam int TOT = NCH * 8,
    localparam int PW = $clog2(TOT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_pulse,
    output logic          live,
    output logic [PW-1:0] cur,
    output logic          frame_start,
    output logic [1:0]    wbank,
    output logic [1:0]    rbank
);
    localparam logic [PW-1:0] LAST = PW'(TOT - 1);

    typedef struct packed {
        logic          locked;
        logic [PW-1:0] pos;
        logic [1:0]    bank;
    } tim_t;

    tim_t q, d;

    always_comb begin
        d           = q;
        live        = q.locked | frame_pulse;
        cur         = frame_pulse ? '0 : q.pos;
        frame_start = live && (cur == '0);
        wbank       = q.bank;
        if (frame_start) begin
            wbank = (q.bank == 2'd2) ? 2'd0 : q.bank + 2'd1;
        end
        rbank    = (wbank == 2'd2) ? 2'd0 : wbank + 2'd1;
        d.bank   = wbank;
        d.locked = q.locked | frame_pulse;
        if (live) begin
            d.pos = (cur == LAST) ? '0 : cur + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/tsi_cmem.sv
module tsi_cmem
    import tsi_pkg::*;
#(
    parameter int NSTR = 4,
    parameter int NCH  = 32,
    localparam int SW = $clog2(NSTR),
    localparam int CW = $clog2(NCH),
    localparam int AW = SW + CW,
    localparam int DEPTH = NSTR * NCH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic [CW-1:0]    rd_ch,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  cm_entry_t        wr_entry,
    input  logic             fill_go,
    output cm_entry_t        rd_entry [NSTR],
    output logic             busy
);
    localparam logic [AW-1:0] LASTI = AW'(DEPTH - 1);

    typedef struct packed {
        cm_entry_t [DEPTH-1:0] shadow;
        cm_entry_t [DEPTH-1:0] active;
        logic                  busy;
        logic [AW-1:0]         idx;
        cm_entry_t             fill;
    } cm_state_t;

    function automatic cm_state_t init_state();
        cm_state_t r;
        r = '0;
        for (int i = 0; i < DEPTH; i++) begin
            r.shadow[i].mode = MODE_HIZ;
            r.active[i].mode = MODE_HIZ;
        end
        return r;
    endfunction

    cm_state_t q, d;

    always_comb begin
        d = q;
        if (frame_start) d.active = q.shadow;
        if (q.busy) begin
            d.shadow[q.idx] = q.fill;
            if (q.idx == LASTI) d.busy = 1'b0;
            else                d.idx  = q.idx + 1'b1;
        end else if (fill_go) begin
            d.busy = 1'b1;
            d.idx  = '0;
            d.fill = wr_entry;
        end else if (wr_en) begin
            d.shadow[wr_addr] = wr_entry;
        end
    end

    generate
        for (genvar s = 0; s < NSTR; s++) begin : g_rd
            logic [AW-1:0] ri;
            assign ri          = {SW'(s), rd_ch};
            assign rd_entry[s] = frame_start ? q.shadow[ri] : q.active[ri];
        end
    endgenerate

    assign busy = q.busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= init_state();
        else        q <= d;
    end
endmodule

// File: rtl/tsi_path.sv
module tsi_path
    import tsi_pkg::*;
#(
    parameter int NSTR = 4,
    parameter int NCH  = 32,
    localparam int SW = $clog2(NSTR),
    localparam int CW = $clog2(NCH),
    localparam int PW = CW + 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            live,
    input  logic [PW-1:0]   cur,
    input  logic [1:0]      wbank,
    input  logic [1:0]      rbank,
    input  logic [NSTR-1:0] rx_data,
    input  cm_entry_t       rd_entry [NSTR],
    output logic [NSTR-1:0] tx_data,
    output logic [NSTR-1:0] tx_en
);
    typedef struct packed {
        logic [NBANK-1:0][NSTR-1:0][NCH-1:0][7:0] mem;
        logic [NSTR-1:0][6:0]                     sh;
        logic [NSTR-1:0]                          tx;
        logic [NSTR-1:0]                          en;
    } path_t;

    path_t q, d;

    logic [CW-1:0] ch;
    logic [2:0]    bpos;
    logic [2:0]    bsel;
    assign ch   = cur[PW-1:3];
    assign bpos = cur[2:0];
    assign bsel = ~bpos;

    always_comb begin
        logic [7:0]    rxb;
        logic [7:0]    src;
        logic [SW-1:0] ss;
        logic [CW-1:0] sc;
        d = q;
        if (live) begin
            for (int s = 0; s < NSTR; s++) begin
                rxb      = {q.sh[s], rx_data[s]};
                d.sh[s]  = rxb[6:0];
                if (bpos == 3'd7) d.mem[wbank][s][ch] = rxb;
            end
        end
        for (int o = 0; o < NSTR; o++) begin
            ss  = rd_entry[o].payload[SW+CW-1:CW];
            sc  = rd_entry[o].payload[CW-1:0];
            src = q.mem[rbank][ss][sc];
            unique case (rd_entry[o].mode)
                MODE_SWITCH: begin d.tx[o] = src[bsel];                  d.en[o] = 1'b1; end
                MODE_MSG:    begin d.tx[o] = rd_entry[o].payload[bsel];  d.en[o] = 1'b1; end
                MODE_HIZ:    begin d.tx[o] = 1'b0;                       d.en[o] = 1'b0; end
                default:     begin d.tx[o] = 1'b1;                       d.en[o] = 1'b1; end
            endcase
            if (!live) begin
                d.tx[o] = 1'b0;
                d.en[o] = 1'b0;
            end
        end
    end

    assign tx_data = q.tx;
    assign tx_en   = q.en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/tdm_tsi.sv
module tdm_tsi
    import tsi_pkg::*;
#(
    parameter int NSTR = 4,
    parameter int NCH  = 32,
    localparam int SW = $clog2(NSTR),
    localparam int CW = $clog2(NCH),
    localparam int AW = SW + CW,
    localparam int PW = CW + 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_pulse,
    input  logic [NSTR-1:0] rx_data,
    output logic [NSTR-1:0] tx_data,
    output logic [NSTR-1:0] tx_en,
    input  logic            host_wr,
    input  logic [AW-1:0]   host_addr,
    input  logic [1:0]      host_mode,
    input  logic [7:0]      host_payload,
    input  logic            fill_go,
    output logic            busy
);
    logic          live;
    logic [PW-1:0] cur;
    logic          frame_start;
    logic [1:0]    wbank;
    logic [1:0]    rbank;
    cm_entry_t     host_entry;
    cm_entry_t     rd_entry [NSTR];

    assign host_entry = '{mode: cm_mode_e'(host_mode), payload: host_payload};

    tsi_timing #(.NCH(NCH)) u_tim (
        .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse),
        .live(live), .cur(cur), .frame_start(frame_start),
        .wbank(wbank), .rbank(rbank)
    );

    tsi_cmem #(.NSTR(NSTR), .NCH(NCH)) u_cm (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .rd_ch(cur[PW-1:3]), .wr_en(host_wr), .wr_addr(host_addr),
        .wr_entry(host_entry), .fill_go(fill_go),
        .rd_entry(rd_entry), .busy(busy)
    );

    tsi_path #(.NSTR(NSTR), .NCH(NCH)) u_path (
        .clk(clk), .rst_n(rst_n), .live(live), .cur(cur),
        .wbank(wbank), .rbank(rbank), .rx_data(rx_data),
        .rd_entry(rd_entry), .tx_data(tx_data), .tx_en(tx_en)
    );
endmodule

// File: rtl/tdm_tsi_chk.sv
module tdm_tsi_chk #(
    parameter int NSTR = 4,
    parameter int NCH  = 32,
    localparam int PW = $clog2(NCH) + 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            frame_pulse,
    input logic            fill_go,
    input logic            busy,
    input logic [NSTR-1:0] tx_data,
    input logic [NSTR-1:0] tx_en,
    input logic            live,
    input logic [PW-1:0]   cur
);
    localparam int DEPTH = NSTR * NCH;
    logic [15:0] busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_len <= '0;
        else if (busy) busy_len <= busy_len + 16'd1;
        else           busy_len <= '0;
    end

    // R4
    released_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_data & ~tx_en) == '0);

    // R8
    fill_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(fill_go));

    // R8
    fill_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == 16'(DEPTH)));

    // R10
    idle_before_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !live |=> (tx_en == '0));

    // R10
    frame_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |=> (frame_pulse || cur == PW'(1)));
endmodule

bind tdm_tsi tdm_tsi_chk #(.NSTR(NSTR), .NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .fill_go(fill_go),
    .busy(busy), .tx_data(tx_data), .tx_en(tx_en), .live(live), .cur(cur)
);

// File: tb/tdm_tsi_tb.sv
module tdm_tsi_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NSTR = 4;
    localparam int NCH  = 32;
    localparam int SW = $clog2(NSTR);
    localparam int CW = $clog2(NCH);
    localparam int AW = SW + CW;
    localparam int TOT = NCH * 8;
    localparam int DEPTH = NSTR * NCH;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            frame_pulse = 1'b0;
    logic [NSTR-1:0] rx_data = '0;
    logic [NSTR-1:0] tx_data;
    logic [NSTR-1:0] tx_en;
    logic            host_wr = 1'b0;
    logic [AW-1:0]   host_addr = '0;
    logic [1:0]      host_mode = '0;
    logic [7:0]      host_payload = '0;
    logic            fill_go = 1'b0;
    logic            busy;

    tdm_tsi #(.NSTR(NSTR), .NCH(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .rx_data(rx_data),
        .tx_data(tx_data), .tx_en(tx_en), .host_wr(host_wr), .host_addr(host_addr),
        .host_mode(host_mode), .host_payload(host_payload), .fill_go(fill_go),
        .busy(busy)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int    errors = 0;
    int    checks = 0;
    bit    done = 0;
    bit    cmp_on = 0;
    bit    fp_en = 0;
    int    fcnt = 0;
    string phase = "R2";

    // reference model state
    bit         m_locked;
    int         m_pos;
    int         m_bank;
    int         m_mem [3][NSTR][NCH];
    int         m_sh [NSTR];
    logic [9:0] m_shadow [DEPTH];
    logic [9:0] m_act [DEPTH];
    bit         m_busy;
    int         m_idx;
    logic [9:0] m_fill;
    logic [NSTR-1:0] exp_tx, exp_en;
    bit         exp_busy;
    string      exp_tag [NSTR];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_locked = 0; m_pos = 0; m_bank = 0; m_busy = 0; m_idx = 0; m_fill = '0;
            for (int b = 0; b < 3; b++)
                for (int s = 0; s < NSTR; s++)
                    for (int c = 0; c < NCH; c++) m_mem[b][s][c] = 0;
            for (int s = 0; s < NSTR; s++) begin m_sh[s] = 0; exp_tag[s] = "R1"; end
            for (int i = 0; i < DEPTH; i++) begin m_shadow[i] = 10'h200; m_act[i] = 10'h200; end
            exp_tx = '0; exp_en = '0; exp_busy = 0;
        end else begin
            bit live, fs;
            int cur, rb, ch, bi, mode, pl;
            live = m_locked || frame_pulse;
            cur  = frame_pulse ? 0 : m_pos;
            fs   = live && (cur == 0);
            if (fs) begin
                m_bank = (m_bank + 1) % 3;
                for (int i = 0; i < DEPTH; i++) m_act[i] = m_shadow[i];
            end
            ch = cur / 8;
            bi = 7 - (cur % 8);
            if (live)
                for (int s = 0; s < NSTR; s++) begin
                    m_sh[s] = ((m_sh[s] << 1) | int'(rx_data[s])) & 255;
                    if (cur % 8 == 7) m_mem[m_bank][s][ch] = m_sh[s];
                end
            rb = (m_bank + 1) % 3;
            for (int o = 0; o < NSTR; o++) begin
                mode = int'(m_act[o * NCH + ch][9:8]);
                pl   = int'(m_act[o * NCH + ch][7:0]);
                if (!live) begin
                    exp_tx[o] = 0; exp_en[o] = 0; exp_tag[o] = "R10";
                end else if (mode == 0) begin
                    exp_tx[o] = m_mem[rb][(pl / NCH) % NSTR][pl % NCH][bi];
                    exp_en[o] = 1; exp_tag[o] = "R2";
                end else if (mode == 1) begin
                    exp_tx[o] = pl[bi]; exp_en[o] = 1; exp_tag[o] = "R5";
                end else if (mode == 2) begin
                    exp_tx[o] = 0; exp_en[o] = 0; exp_tag[o] = "R4";
                end else begin
                    exp_tx[o] = 1; exp_en[o] = 1; exp_tag[o] = "R6";
                end
            end
            if (m_busy) begin
                m_shadow[m_idx] = m_fill;
                if (m_idx == DEPTH - 1) m_busy = 0;
                else m_idx++;
            end else if (fill_go) begin
                m_busy = 1; m_idx = 0; m_fill = {host_mode, host_payload};
            end else if (host_wr) begin
                m_shadow[host_addr] = {host_mode, host_payload};
            end
            if (live) begin
                m_pos = (cur == TOT - 1) ? 0 : cur + 1;
                m_locked = 1;
            end
            exp_busy = m_busy;
        end
    end

    // stimulus of serial data and frame pulses
    always @(negedge clk) begin
        rx_data = NSTR'($urandom);
        if (fp_en) begin
            frame_pulse = (fcnt == 0);
            fcnt = (fcnt + 1) % TOT;
        end else begin
            frame_pulse = 0;
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (cmp_on && rst_n && !done) begin
            for (int o = 0; o < NSTR; o++) begin
                checks++;
                if (tx_data[o] !== exp_tx[o] || tx_en[o] !== exp_en[o]) begin
                    errors++;
                    $display("FAIL %s (phase %s) stream %0d: got data=%b en=%b expected data=%b en=%b at %0t",
                             exp_tag[o], phase, o, tx_data[o], tx_en[o], exp_tx[o], exp_en[o], $time);
                end
            end
            checks++;
            if (busy !== exp_busy) begin
                errors++;
                $display("FAIL R8 (phase %s) busy: got %b expected %b at %0t", phase, busy, exp_busy, $time);
            end
        end
    end

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic host_write(input int s, input int c, input int mode, input int pl);
        @(negedge clk);
        host_wr = 1; host_addr = AW'(s * NCH + c);
        host_mode = 2'(mode); host_payload = 8'(pl);
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic start_fill(input int mode, input int pl);
        @(negedge clk);
        fill_go = 1; host_mode = 2'(mode); host_payload = 8'(pl);
        @(negedge clk);
        fill_go = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        finish_run();
    end

    initial begin
        wait_cycles(3);
        // R1: reset state at the ports
        checks++;
        if (tx_en !== '0 || tx_data !== '0 || busy !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: got en=%b data=%b busy=%b expected 0 0 0", tx_en, tx_data, busy);
        end
        rst_n = 1;
        cmp_on = 1;
        // R10: no frame pulse yet, outputs must stay disabled
        phase = "R10";
        wait_cycles(100);
        fp_en = 1;
        // R1: every entry still high-Z for a full frame
        phase = "R1";
        wait_cycles(TOT + 40);
        // R7: writes in the middle of a frame, effect from next boundary
        phase = "R7";
        for (int c = 0; c < 8; c++) host_write(0, c, 0, 1 * NCH + c + 2);
        host_write(1, 5, 1, 8'h3C);
        host_write(3, 9, 3, 0);
        // R2: broadcast of stream 0 channel 31 to two outputs
        host_write(2, 1, 0, 0 * NCH + 31);
        host_write(3, 31, 0, 0 * NCH + 31);
        // R3: channel read in the slot where its source is being written
        host_write(2, 20, 0, 3 * NCH + 20);
        host_write(1, 0, 0, 2 * NCH + 31);
        wait_cycles(TOT);
        phase = "R3";
        wait_cycles(3 * TOT);
        // R8: block fill with a switched source, then R9 disturbances
        phase = "R8";
        start_fill(0, 2 * NCH + 7);
        phase = "R9";
        host_write(0, 4, 3, 0);
        start_fill(1, 8'hFF);
        host_write(3, 30, 1, 8'h11);
        wait_cycles(DEPTH + 3 * TOT);
        // R5: block fill with a message byte
        phase = "R5";
        start_fill(1, 8'h81);
        wait_cycles(DEPTH + 2 * TOT);
        // R6: block fill with drive-high
        phase = "R6";
        start_fill(3, 0);
        wait_cycles(DEPTH + 2 * TOT);
        // R4: back to high-Z everywhere
        phase = "R4";
        start_fill(2, 0);
        wait_cycles(DEPTH + 2 * TOT);
        finish_run();
    end
endmodule